// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single memory requests from a processor core into external bus cycles on a multiplexed address/data bus. A request is one of three kinds: an instruction fetch, a data read or a data write. Each carries a 16-bit address, and a write also carries a byte. The block drives an address latch enable, a program-store strobe for fetches, read and write strobes for data accesses, the low address byte and then the data on a shared byte lane, and the high address byte on a separate lane. For fetches and reads it samples the byte returned on the shared lane and hands it back with a one-clock done pulse.

Every strobe edge sits at a fixed count of clocks from the start of the cycle, and all of the counts are parameters. Fetch cycles and data cycles have their own shapes. Only one cycle runs at a time. A busy output tells the core when a new request would be refused, and a request presented in the last clock of a cycle starts the next cycle at once. The shared lane is split into an output byte, an output enable and an input byte, so the pad and any open-drain behaviour stay outside the block.

Top module: `xbus_seq`

## Requirements
- R1: Reset, whether applied at the start or in the middle of a cycle, sets these outputs at once: ale low, psen_n, rd_n and wr_n high, ad_oe low, busy low, done low and rdata zero.
- R2: A request is accepted on a clock edge where req_valid is high and busy is low. The request kind is coded 00 for fetch, 01 for read and 10 for write. ale is high for the ALE_W clocks (default 2) that follow the accepting edge, and then low for the rest of the cycle.
- R3: ad_oe is high and ad_o carries address bits 7:0 from the first clock of ale until ADDR_HOLD clocks (default 1) after ale falls.
- R4: In a fetch cycle, psen_n goes low FETCH_DLY clocks (default 1) after ale falls and stays low for FETCH_W clocks (default 3). rd_n and wr_n stay high.
- R5: In a read or write cycle, the matching strobe (rd_n for a read, wr_n for a write) goes low DATA_DLY clocks (default 3) after ale falls and stays low for DATA_W clocks (default 6). The other two strobes stay high.
- R6: In a write cycle, ad_oe is high and ad_o carries the write byte from WR_SETUP clocks (default 1) before wr_n falls until WR_HOLD clocks (default 1) after wr_n rises.
- R7: ad_oe is low in every clock in which psen_n or rd_n is low.
- R8: In a fetch or read, rdata takes the value on ad_i at the last clock edge before the strobe rises, and then holds it. A write leaves rdata unchanged. done is high for exactly one clock, the final clock of the cycle, which is the TAIL-th clock (default 1) after the strobe returns high.
- R9: ah_o carries address bits 15:8 from the first clock of ale to the end of the cycle.
- R10: busy is high from the first clock of a cycle until, but not including, its final clock. A request made while busy is high is ignored. A request made in the final clock is accepted, so ale rises again one clock after the strobe returns high (with TAIL = 1).
- R11: A request with kind code 11 is ignored. No strobe moves and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts are in its periods |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 ignored |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A request would be refused this clock |
| done | output | 1 | One-clock pulse in the final clock of a cycle |
| rdata | output | 8 | Byte captured by the last fetch or read |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared lane output: low address byte, then write data |
| ad_oe | output | 1 | Shared lane output enable |
| ad_i | input | 8 | Shared lane input |
| ah_o | output | 8 | High address byte |

## Verification
The bench puts the correct read byte on ad_i only in the final clock of the strobe-low window and its inverse at all other times. A design that samples one edge early or late therefore returns the complement. Each clock of every cycle is compared pin by pin, which exposes a strobe that is off by one clock, a lane that is still driven while psen_n or rd_n is low, and write data that is dropped as wr_n rises. Directed cases cover a request made during a busy cycle, which a faulty design would start or merge into the running cycle, and a request made in the final clock, which a faulty design would delay by one clock or lose. They also cover the reserved kind code, which a faulty design would run as a cycle, and a reset in the middle of a write, which a faulty design would leave with wr_n low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [1:0] {
      XK_FETCH = 2'b00,
      XK_READ  = 2'b01,
      XK_WRITE = 2'b10,
      XK_RSVD  = 2'b11
   } xbus_kind_e;

   typedef struct packed {
      logic ale;
      logic psen_n;
      logic rd_n;
      logic wr_n;
      logic oe;
      logic sel_wd;
   } xbus_pins_t;

   localparam xbus_pins_t XBUS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                        wr_n: 1'b1, oe: 1'b0, sel_wd: 1'b0};

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
   import xbus_pkg::*;
#(
   parameter int CW    = 4,
   parameter int F_END = 6,
   parameter int D_END = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  xbus_kind_e    req_kind,
   output logic          act,
   output logic [CW-1:0] ph,
   output xbus_kind_e    kind,
   output logic          act_nx,
   output logic [CW-1:0] ph_nx,
   output xbus_kind_e    kind_nx,
   output logic          accept,
   output logic          busy,
   output logic          last
);

   logic [CW-1:0] end_ph;

   always_comb begin
      end_ph = (kind == XK_FETCH) ? CW'(F_END) : CW'(D_END);
      last   = act && (ph == end_ph);
      busy   = act && !last;
      accept = req_valid && !busy && (req_kind != XK_RSVD);
   end

   always_comb begin
      act_nx  = act;
      ph_nx   = ph;
      kind_nx = kind;
      if (accept) begin
         act_nx  = 1'b1;
         ph_nx   = '0;
         kind_nx = req_kind;
      end else if (last) begin
         act_nx = 1'b0;
         ph_nx  = '0;
      end else if (act) begin
         ph_nx = ph + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         ph   <= '0;
         kind <= XK_FETCH;
      end else begin
         act  <= act_nx;
         ph   <= ph_nx;
         kind <= kind_nx;
      end
   end

   assert_busy_keeps_cycle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (act && $stable(kind) && ph == $past(ph) + 1'b1));

   assert_phase_in_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (ph <= end_ph));

   assert_rsvd_ignored_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!act && req_kind == XK_RSVD) |=> !act);

endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes
   import xbus_pkg::*;
#(
   parameter int CW        = 4,
   parameter int ALE_W     = 2,
   parameter int ADDR_HOLD = 1,
   parameter int F_ON      = 3,
   parameter int F_OFF     = 6,
   parameter int D_ON      = 5,
   parameter int D_OFF     = 11,
   parameter int WD_ON     = 4,
   parameter int WD_OFF    = 12,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act,
   input  logic [CW-1:0] ph,
   input  xbus_kind_e    kind,
   input  logic          act_nx,
   input  logic [CW-1:0] ph_nx,
   input  xbus_kind_e    kind_nx,
   output xbus_pins_t    pins,
   output logic          samp
);

   function automatic xbus_pins_t decode(input logic a, input logic [CW-1:0] p,
                                         input xbus_kind_e k);
      xbus_pins_t r;
      int         q;
      q        = int'(p);
      r        = XBUS_IDLE;
      r.ale    = a && (q < ALE_W);
      r.psen_n = !(a && k == XK_FETCH && q >= F_ON && q < F_OFF);
      r.rd_n   = !(a && k == XK_READ  && q >= D_ON && q < D_OFF);
      r.wr_n   = !(a && k == XK_WRITE && q >= D_ON && q < D_OFF);
      if (a && q < ALE_W + ADDR_HOLD) begin
         r.oe = 1'b1;
      end else if (a && k == XK_WRITE && q >= WD_ON && q < WD_OFF) begin
         r.oe     = 1'b1;
         r.sel_wd = 1'b1;
      end
      return r;
   endfunction

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pins <= XBUS_IDLE;
            else        pins <= decode(act_nx, ph_nx, kind_nx);
         end
      end else begin : g_comb
         always_comb pins = decode(act, ph, kind);
      end
   endgenerate

   always_comb begin
      if (kind == XK_FETCH) samp = act && (int'(ph) == F_OFF - 1);
      else                  samp = act && (kind == XK_READ) && (int'(ph) == D_OFF - 1);
   end

   assert_single_strobe_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~pins.psen_n, ~pins.rd_n, ~pins.wr_n}) <= 1);

   assert_lane_free_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pins.psen_n || !pins.rd_n) |-> !pins.oe);

   assert_ale_apart_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      pins.ale |-> (pins.psen_n && pins.rd_n && pins.wr_n));

   generate
      if (WD_OFF > D_OFF) begin : g_hold_chk
         assert_wdata_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pins.wr_n) |-> (pins.oe && pins.sel_wd));
      end
   endgenerate

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ALE_W     = 2,
   parameter int ADDR_HOLD = 1,
   parameter int FETCH_DLY = 1,
   parameter int FETCH_W   = 3,
   parameter int DATA_DLY  = 3,
   parameter int DATA_W    = 6,
   parameter int WR_SETUP  = 1,
   parameter int WR_HOLD   = 1,
   parameter int TAIL      = 1,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic [15:0] req_addr,
   input  logic [7:0]  req_wdata,
   output logic        busy,
   output logic        done,
   output logic [7:0]  rdata,
   output logic        ale,
   output logic        psen_n,
   output logic        rd_n,
   output logic        wr_n,
   output logic [7:0]  ad_o,
   output logic        ad_oe,
   input  logic [7:0]  ad_i,
   output logic [7:0]  ah_o
);

   localparam int F_ON    = ALE_W + FETCH_DLY;
   localparam int F_OFF   = F_ON + FETCH_W;
   localparam int D_ON    = ALE_W + DATA_DLY;
   localparam int D_OFF   = D_ON + DATA_W;
   localparam int WD_ON   = D_ON - WR_SETUP;
   localparam int WD_OFF  = D_OFF + WR_HOLD;
   localparam int F_END   = F_OFF - 1 + TAIL;
   localparam int D_END   = D_OFF - 1 + TAIL;
   localparam int MAX_END = (F_END > D_END) ? F_END : D_END;
   localparam int CW      = $clog2(MAX_END + 1);

   generate
      if (ALE_W < 1 || FETCH_W < 1 || DATA_W < 1 || TAIL < 1) begin : g_bad_width
         $error("xbus_seq: pulse widths and TAIL must be at least one clock");
      end
      if (ADDR_HOLD > FETCH_DLY) begin : g_bad_fetch
         $error("xbus_seq: address hold overlaps the fetch strobe");
      end
      if (ADDR_HOLD + WR_SETUP > DATA_DLY) begin : g_bad_write
         $error("xbus_seq: address hold overlaps write data setup");
      end
      if (WR_HOLD > TAIL) begin : g_bad_hold
         $error("xbus_seq: write hold runs past the end of the cycle");
      end
   endgenerate

   xbus_kind_e    kind, kind_nx;
   logic          act, act_nx, accept, last, samp;
   logic [CW-1:0] ph, ph_nx;
   logic [15:0]   addr_q;
   logic [7:0]    wdata_q;
   xbus_pins_t    pins;

   xbus_timer #(.CW(CW), .F_END(F_END), .D_END(D_END)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_kind (xbus_kind_e'(req_kind)),
      .act      (act),
      .ph       (ph),
      .kind     (kind),
      .act_nx   (act_nx),
      .ph_nx    (ph_nx),
      .kind_nx  (kind_nx),
      .accept   (accept),
      .busy     (busy),
      .last     (last)
   );

   xbus_strobes #(
      .CW(CW), .ALE_W(ALE_W), .ADDR_HOLD(ADDR_HOLD), .F_ON(F_ON), .F_OFF(F_OFF),
      .D_ON(D_ON), .D_OFF(D_OFF), .WD_ON(WD_ON), .WD_OFF(WD_OFF), .REG_OUT(REG_OUT)
   ) u_strobes (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .ph     (ph),
      .kind   (kind),
      .act_nx (act_nx),
      .ph_nx  (ph_nx),
      .kind_nx(kind_nx),
      .pins   (pins),
      .samp   (samp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (samp) rdata <= ad_i;
      end
   end

   always_comb begin
      ale    = pins.ale;
      psen_n = pins.psen_n;
      rd_n   = pins.rd_n;
      wr_n   = pins.wr_n;
      ad_oe  = pins.oe;
      ad_o   = pins.sel_wd ? wdata_q : addr_q[7:0];
      ah_o   = addr_q[15:8];
      done   = last;
   end

   assert_high_addr_steady_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (act && !last) |=> $stable(ah_o));

   assert_done_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_rdata_kept_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !samp |=> $stable(rdata));

   assert_idle_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !done |-> (psen_n && rd_n && wr_n));

endmodule

// File: tb/xbus_seq_test.sv
module xbus_seq_test;

   localparam int AW = 2, AH = 1, FD = 1, FW = 3, DD = 3, DW = 6, WS = 1, WH = 1, TL = 1;
   localparam int F_ON = AW + FD, F_OFF = F_ON + FW, D_ON = AW + DD, D_OFF = D_ON + DW;

   // kind[33:32] addr[31:16] wdata[15:8] bus[7:0]
   localparam logic [33:0] VEC [0:5] = '{
      {2'd0, 16'h1234, 8'h00, 8'hA5},
      {2'd1, 16'hFF00, 8'h00, 8'h3C},
      {2'd2, 16'h00FF, 8'h5A, 8'h00},
      {2'd0, 16'h8001, 8'h00, 8'hFF},
      {2'd2, 16'hABCD, 8'hC3, 8'h11},
      {2'd1, 16'h0000, 8'h00, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0, ad_i = '0;
   logic busy, done, ale, psen_n, rd_n, wr_n, ad_oe;
   logic [7:0] rdata, ad_o, ah_o;
   int n_chk = 0, n_err = 0;
   logic [7:0] last_rd = 8'h00;

   always #2 clk = ~clk;

   xbus_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ah_o(ah_o)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   task automatic start(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_vec(input logic [33:0] v);
      logic [1:0] k;
      logic [15:0] a;
      logic [7:0] wd, bv;
      int lst, fin;
      k = v[33:32]; a = v[31:16]; wd = v[15:8]; bv = v[7:0];
      lst = (k == 2'd0) ? F_OFF - 1 : D_OFF - 1;
      fin = lst + TL;
      ad_i = ~bv;
      start(k, a, wd);
      for (int c = 0; c <= fin; c++) begin
         ad_i = (c == lst) ? bv : ~bv;
         check("R2 ale", 16'(ale), 16'(c < AW));
         check("R4 psen_n", 16'(psen_n), 16'(!(k == 2'd0 && c >= F_ON && c < F_OFF)));
         check("R5 rd_n", 16'(rd_n), 16'(!(k == 2'd1 && c >= D_ON && c < D_OFF)));
         check("R5 wr_n", 16'(wr_n), 16'(!(k == 2'd2 && c >= D_ON && c < D_OFF)));
         if (c < AW + AH) begin
            check("R3 ad_oe", 16'(ad_oe), 16'd1);
            check("R3 ad_o", 16'(ad_o), 16'(a[7:0]));
         end else if (k == 2'd2 && c >= D_ON - WS && c < D_OFF + WH) begin
            check("R6 ad_oe", 16'(ad_oe), 16'd1);
            check("R6 ad_o", 16'(ad_o), 16'(wd));
         end else begin
            check("R7 ad_oe", 16'(ad_oe), 16'd0);
         end
         check("R9 ah_o", 16'(ah_o), 16'(a[15:8]));
         check("R10 busy", 16'(busy), 16'(c < fin));
         check("R8 done", 16'(done), 16'(c == fin));
         if (c != fin) @(negedge clk);
      end
      if (k != 2'd2) last_rd = bv;
      check("R8 rdata", 16'(rdata), 16'(last_rd));
   endtask

   initial begin
      #800000;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs after reset
      check("R1 ale", 16'(ale), 16'd0);
      check("R1 strobes", 16'({psen_n, rd_n, wr_n}), 16'b111);
      check("R1 ad_oe", 16'(ad_oe), 16'd0);
      check("R1 busy/done", 16'({busy, done}), 16'd0);
      check("R1 rdata", 16'(rdata), 16'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 6; i++) run_vec(VEC[i]);

      // R11: reserved kind code is ignored
      start(2'd3, 16'h5555, 8'h55);
      for (int c = 0; c < 3; c++) begin
         check("R11 busy", 16'(busy), 16'd0);
         check("R11 ale/strobes", 16'({ale, psen_n, rd_n, wr_n}), 16'b0111);
         @(negedge clk);
      end

      // R10: request during busy is ignored
      start(2'd0, 16'h4242, 8'h00);
      @(negedge clk); @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h9999; req_wdata = 8'h99;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 3; c <= F_OFF - 1 + TL; c++) begin
         check("R10 wr_n stays high", 16'(wr_n), 16'd1);
         check("R10 ah_o kept", 16'(ah_o), 16'h42);
         if (c != F_OFF - 1 + TL) @(negedge clk);
      end
      @(negedge clk);
      check("R10 no extra cycle ale", 16'(ale), 16'd0);
      check("R10 no extra cycle busy", 16'(busy), 16'd0);

      // R10: request in the final clock starts next cycle at once
      start(2'd1, 16'h1357, 8'h00);
      for (int c = 1; c <= D_OFF - 1 + TL; c++) @(negedge clk);
      check("R8 done at final clock", 16'(done), 16'd1);
      check("R5 rd_n back high", 16'(rd_n), 16'd1);
      req_valid = 1'b1; req_kind = 2'd0; req_addr = 16'h7700;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 back-to-back ale", 16'(ale), 16'd1);
      check("R10 back-to-back busy", 16'(busy), 16'd1);
      check("R9 back-to-back ah_o", 16'(ah_o), 16'h77);
      for (int c = 0; c < 20 && busy; c++) @(negedge clk);
      @(negedge clk);

      // R1: reset in the middle of a write
      start(2'd2, 16'h2468, 8'h81);
      for (int c = 1; c <= D_ON + 1; c++) @(negedge clk);
      check("R5 wr_n low mid-write", 16'(wr_n), 16'd0);
      rst_n = 1'b0;
      #1;
      check("R1 wr_n after reset", 16'(wr_n), 16'd1);
      check("R1 ad_oe after reset", 16'(ad_oe), 16'd0);
      check("R1 busy after reset", 16'(busy), 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      summary();
      $finish;
   end

endmodule